// File: doc/BRIEF.md
# Nine-Bit Command Word SPI Transmitter

This block takes one display-controller command from an upstream valid/ready handshake and sends it on a write-only SPI link. A command is an 8-bit opcode plus up to two 8-bit arguments. Each byte is turned into a 9-bit word by putting a type flag in front of it: 0 for the opcode and 1 for an argument. The words are joined in order, placed at the top of a frame of two, three or four bytes, and the unused bits at the bottom are filled with zeros. The frame is then shifted out most significant bit first.

The serial side uses SPI mode 3. The serial clock idles high. The receiver samples on the rising edge, and the data line changes only on falling edges. Chip select is active low and stays low for the whole frame. The serial clock is made from the system clock by an even divider. After every frame, or after an abort, chip select stays high for at least one serial clock period before the next command is accepted. A one-cycle `done` pulse marks each frame that completes. A command whose argument count is 3 is taken from the handshake and dropped.

Top module: `cmd9_spi_tx`

## Requirements
- R1: The first 9-bit word of a frame is the type flag 0 followed by the opcode. Each argument word is the type flag 1 followed by that argument byte. Argument 0 is sent before argument 1.
- R2: A command accepted with `in_count` = 3 causes no chip-select activity and no `done` pulse, and `in_ready` stays high.
- R3: A frame with `in_count` = n (0, 1 or 2) has exactly 8·(n+2) rising serial clock edges while chip select is low.
- R4: The 9·(n+1) word bits occupy the top of the frame. The remaining 7−n bits at the bottom are zero.
- R5: When chip select is high, the serial clock is high. MOSI is stable at each rising edge. Frame bits go out most significant first.
- R6: Chip select goes low when a frame is accepted. It stays low until half a serial clock period after the last rising edge, and only then rises.
- R7: Within a frame, consecutive rising serial clock edges are `SCLK_DIV` system clock cycles apart.
- R8: `in_ready` is low from the cycle after acceptance until chip select has been high for at least `SCLK_DIV` system clock cycles.
- R9: `done` is a single-cycle pulse. It is raised once per completed frame, in the cycle in which chip select rises.
- R10: `abort` during a frame raises chip select and leaves the serial clock high in the next cycle. No `done` pulse is given, and the idle gap of R8 still applies. `abort` has no effect while idle.
- R11: After reset, chip select and the serial clock are high, `done` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Block can accept a command |
| in_opcode | input | 8 | Opcode byte |
| in_param0 | input | 8 | First argument byte |
| in_param1 | input | 8 | Second argument byte |
| in_count | input | 2 | Number of arguments (0..2 legal, 3 dropped) |
| abort | input | 1 | Cut the current frame short |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| done | output | 1 | One-cycle pulse at the end of each completed frame |

## Verification
Some rules are checked by assertions on every cycle:
- the serial clock idles high whenever chip select is high;
- MOSI does not move at a rising edge;
- `in_ready` is low while chip select is low;
- `done` is a single pulse that coincides with chip select rising;
- an abort releases the bus at once, and a count-3 command leaves the bus untouched.

Other properties can only be shown by the bench's scenarios, which act as an SPI slave:
- the frame content (type flags, word order and zero padding), using the full opcode sweep and the argument patterns;
- the exact number of clock edges;
- the serial clock period;
- the length of the idle gap after each frame.

// File: rtl/cmd9_pkg.sv
package cmd9_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = BYTE_W + 1;
  localparam int unsigned FRAME_W = 4 * BYTE_W;
  localparam int unsigned NBITS_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } tx_state_t;
endpackage

// File: rtl/cmd9_frame_pack.sv
module cmd9_frame_pack
  import cmd9_pkg::*;
(
  input  logic [BYTE_W-1:0]  opcode,
  input  logic [BYTE_W-1:0]  arg0,
  input  logic [BYTE_W-1:0]  arg1,
  input  logic [1:0]         count,
  output logic [FRAME_W-1:0] frame,
  output logic [NBITS_W-1:0] nbits,
  output logic               legal
);
  logic [WORD_W-1:0] w_op, w_a0, w_a1;

  assign w_op  = {1'b0, opcode};
  assign w_a0  = {1'b1, arg0};
  assign w_a1  = {1'b1, arg1};
  assign legal = (count != 2'd3);

  always_comb begin
    frame = '0;
    nbits = NBITS_W'(2 * BYTE_W);
    case (count)
      2'd0: begin
        frame[FRAME_W-1 -: WORD_W] = w_op;
        nbits = NBITS_W'(2 * BYTE_W);
      end
      2'd1: begin
        frame[FRAME_W-1 -: 2*WORD_W] = {w_op, w_a0};
        nbits = NBITS_W'(3 * BYTE_W);
      end
      2'd2: begin
        frame[FRAME_W-1 -: 3*WORD_W] = {w_op, w_a0, w_a1};
        nbits = NBITS_W'(4 * BYTE_W);
      end
      default: begin
        frame = '0;
        nbits = '0;
      end
    endcase
  end
endmodule

// File: rtl/cmd9_sclk_div.sv
module cmd9_sclk_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick)   cnt_d = '0;
    else if (en)       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cmd9_spi_shift.sv
module cmd9_spi_shift
  import cmd9_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NBITS_W-1:0] nbits,
  input  logic               abort,
  input  logic               tick,
  output logic               busy,
  output logic               div_clr,
  output logic               idle,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               done
);
  tx_state_t          st_q, st_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [NBITS_W-1:0] left_q, left_d;
  logic               first_q, first_d;
  logic               gap_half_q, gap_half_d;
  logic               sclk_q, sclk_d;
  logic               cs_q, cs_d;
  logic               done_q, done_d;

  always_comb begin
    st_d       = st_q;
    sreg_d     = sreg_q;
    left_d     = left_q;
    first_d    = first_q;
    gap_half_d = gap_half_q;
    sclk_d     = sclk_q;
    cs_d       = cs_q;
    done_d     = 1'b0;
    div_clr    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_SHIFT;
          sreg_d  = frame;
          left_d  = nbits;
          first_d = 1'b1;
          cs_d    = 1'b0;
          sclk_d  = 1'b1;
          div_clr = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (abort) begin
          st_d       = ST_GAP;
          cs_d       = 1'b1;
          sclk_d     = 1'b1;
          gap_half_d = 1'b0;
          div_clr    = 1'b1;
        end else if (tick) begin
          if (sclk_q) begin
            if (left_q == '0) begin
              st_d       = ST_GAP;
              cs_d       = 1'b1;
              done_d     = 1'b1;
              gap_half_d = 1'b0;
              div_clr    = 1'b1;
            end else begin
              sclk_d  = 1'b0;
              first_d = 1'b0;
              if (!first_q) sreg_d = {sreg_q[FRAME_W-2:0], 1'b0};
            end
          end else begin
            sclk_d = 1'b1;
            left_d = left_q - NBITS_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_half_q) st_d = ST_IDLE;
          else            gap_half_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sreg_q     <= '0;
      left_q     <= '0;
      first_q    <= 1'b0;
      gap_half_q <= 1'b0;
      sclk_q     <= 1'b1;
      cs_q       <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      sreg_q     <= sreg_d;
      left_q     <= left_d;
      first_q    <= first_d;
      gap_half_q <= gap_half_d;
      sclk_q     <= sclk_d;
      cs_q       <= cs_d;
      done_q     <= done_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign idle = (st_q == ST_IDLE);
  assign sclk = sclk_q;
  assign mosi = sreg_q[FRAME_W-1];
  assign cs_n = cs_q;
  assign done = done_q;

  // R5: clock rests high outside a frame
  p_sclk_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);
  // R5: data line holds still across the sampling edge
  p_mosi_stable_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sreg_q[FRAME_W-1]));
  // R9: single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: pulse lines up with chip-select release
  p_done_with_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $rose(cs_q));
  // R10: abort frees the bus at once, no completion pulse
  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && st_q == ST_SHIFT) |=> (cs_q && sclk_q && !done_q));
endmodule

// File: rtl/cmd9_spi_tx.sv
module cmd9_spi_tx
  import cmd9_pkg::*;
#(
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_opcode,
  input  logic [BYTE_W-1:0] in_param0,
  input  logic [BYTE_W-1:0] in_param1,
  input  logic [1:0]        in_count,
  input  logic              abort,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic              done
);
  localparam int unsigned HALF_DIV = (SCLK_DIV >= 2) ? SCLK_DIV / 2 : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [FRAME_W-1:0] frame;
  logic [NBITS_W-1:0] nbits;
  logic               legal, start, tick, busy, div_clr, idle;

  cmd9_frame_pack u_pack (
    .opcode (in_opcode),
    .arg0   (in_param0),
    .arg1   (in_param1),
    .count  (in_count),
    .frame  (frame),
    .nbits  (nbits),
    .legal  (legal)
  );

  cmd9_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (busy),
    .clr   (div_clr),
    .tick  (tick)
  );

  assign in_ready = idle;
  assign start    = in_valid && idle && legal;

  cmd9_spi_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start   (start),
    .frame   (frame),
    .nbits   (nbits),
    .abort   (abort),
    .tick    (tick),
    .busy    (busy),
    .div_clr (div_clr),
    .idle    (idle),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .cs_n    (spi_cs_n),
    .done    (done)
  );

  // R8: no new command while a frame owns the bus
  p_ready_low_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !spi_cs_n |-> !in_ready);
  // R2: illegal count leaves the bus quiet
  p_drop_count3_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && in_ready && in_count == 2'd3) |=> (spi_cs_n && in_ready));
endmodule

// File: tb/cmd9_spi_tx_tb.sv
module cmd9_spi_tx_tb;
  localparam int SCLK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0, in_param0 = '0, in_param1 = '0;
  logic [1:0] in_count = '0;
  logic       abort = 1'b0;
  logic       spi_sclk, spi_mosi, spi_cs_n, done;

  int checks = 0, fails = 0;
  int cyc = 0, done_cnt = 0, cs_falls = 0, nb = 0;
  int t_rise = 0, last_sclk = -1, period_err = 0, ready_err = 0, idle_err = 0;
  logic [31:0] cap = '0;

  always #2.5 clk = ~clk;

  cmd9_spi_tx #(.SCLK_DIV(SCLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_param0(in_param0), .in_param1(in_param1),
    .in_count(in_count), .abort(abort), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .done(done)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) done_cnt = done_cnt + 1;
  end

  always @(negedge spi_cs_n) begin
    nb = 0; cap = '0; last_sclk = -1; cs_falls = cs_falls + 1;
  end
  always @(posedge spi_cs_n) t_rise = cyc;

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (nb < 32) cap[31-nb] = spi_mosi;
      nb = nb + 1;
      if (last_sclk >= 0 && (cyc - last_sclk) != SCLK_DIV) period_err = period_err + 1;
      last_sclk = cyc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n && in_ready) ready_err = ready_err + 1;
      if (spi_cs_n && !spi_sclk) idle_err = idle_err + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 2000 && !in_ready; k++) @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] a0, input logic [7:0] a1,
                       input logic [1:0] n);
    wait_ready();
    in_opcode = op; in_param0 = a0; in_param1 = a1; in_count = n; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frame_test(input logic [7:0] op, input logic [7:0] a0, input logic [7:0] a1,
                            input int n);
    logic [31:0] exp, pad_mask;
    int d0, pe0, gap;
    d0 = done_cnt; pe0 = period_err;
    case (n)
      0: exp = {1'b0, op, 23'd0};
      1: exp = {1'b0, op, 1'b1, a0, 14'd0};
      default: exp = {1'b0, op, 1'b1, a0, 1'b1, a1, 5'd0};
    endcase
    issue(op, a0, a1, 2'(n));
    wait_ready();
    gap = cyc - t_rise;
    chk(nb == (n + 2) * 8, "R3 edge count", nb, (n + 2) * 8);
    chk(cap[31] == 1'b0 && (n < 1 || cap[22]) && (n < 2 || cap[13]), "R1 type flags",
        cap, exp);
    pad_mask = ((32'd1 << (7 - n)) - 32'd1) << (32 - (n + 2) * 8);
    chk((cap & pad_mask) == 0, "R4 zero padding", cap & pad_mask, 0);
    chk(cap == exp, "R5 R6 frame bits msb first", cap, exp);
    chk(done_cnt - d0 == 1, "R9 done per frame", done_cnt - d0, 1);
    chk(gap >= SCLK_DIV, "R8 idle gap", gap, SCLK_DIV);
    chk(period_err == pe0, "R7 sclk period", period_err - pe0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(spi_cs_n == 1'b1, "R11 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R11 sclk", spi_sclk, 1);
    chk(done == 1'b0, "R11 done", done, 0);
    chk(in_ready == 1'b1, "R11 ready", in_ready, 1);

    // no-argument commands: full opcode sweep
    for (int i = 0; i < 256; i++) frame_test(8'(i), 8'h00, 8'h00, 0);
    // one argument
    for (int i = 0; i < 64; i++) frame_test(8'(i * 4 + 1), 8'(i * 37) ^ 8'hA5, 8'h00, 1);
    frame_test(8'hFF, 8'hFF, 8'h00, 1);
    frame_test(8'h00, 8'h00, 8'hFF, 1);
    // two arguments
    for (int i = 0; i < 64; i++) frame_test(8'(255 - i * 3), 8'(i * 11), 8'(i * 53) ^ 8'h3C, 2);
    frame_test(8'hFF, 8'hFF, 8'hFF, 2);
    frame_test(8'h00, 8'h00, 8'h00, 2);

    // R2: count of 3 is dropped
    begin
      int cf0, d0;
      cf0 = cs_falls; d0 = done_cnt;
      issue(8'hB8, 8'h12, 8'h34, 2'd3);
      repeat (50) @(negedge clk);
      chk(cs_falls == cf0, "R2 no cs activity", cs_falls - cf0, 0);
      chk(done_cnt == d0, "R2 no done", done_cnt - d0, 0);
      chk(in_ready == 1'b1, "R2 ready high", in_ready, 1);
    end

    // R10: abort mid-frame
    begin
      int d0, gap;
      d0 = done_cnt;
      issue(8'h5A, 8'hC3, 8'h81, 2'd2);
      repeat (40) @(negedge clk);
      chk(spi_cs_n == 1'b0, "R6 cs low mid frame", spi_cs_n, 0);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(spi_cs_n == 1'b1, "R10 cs released", spi_cs_n, 1);
      chk(spi_sclk == 1'b1, "R10 sclk high", spi_sclk, 1);
      wait_ready();
      gap = cyc - t_rise;
      chk(done_cnt == d0, "R10 no done on abort", done_cnt - d0, 0);
      chk(nb < 32, "R10 frame cut short", nb, 32);
      chk(gap >= SCLK_DIV, "R10 idle gap after abort", gap, SCLK_DIV);
    end

    // R10: abort while idle has no effect
    begin
      int cf0;
      cf0 = cs_falls;
      abort = 1'b1;
      repeat (3) @(negedge clk);
      abort = 1'b0;
      chk(in_ready == 1'b1 && spi_cs_n == 1'b1 && cs_falls == cf0, "R10 idle abort ignored",
          {in_ready, spi_cs_n}, 2'b11);
      frame_test(8'h29, 8'h16, 8'h00, 1);
    end

    chk(ready_err == 0, "R8 ready low during frame", ready_err, 0);
    chk(idle_err == 0, "R5 sclk idles high", idle_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule